// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit up-counter that software can read but never load. It counts ticks taken from one of two sources. The first is the system clock divided by a fixed ratio. The second is the rising edge of an external clock pin. A power-of-two prescaler sits after the chosen source. The count can also be forced to zero by a rising edge on an external clear pin.

Four capture channels copy the count when their input pin shows the selected edge. The edge can be rising, falling or both. Three compare registers act on a bank of output pins whenever the count takes a new value equal to them:
- the first drives masked pins high;
- the second drives masked pins low;
- the third inverts masked pins.

Every capture, every compare hit and the overflow raise their own sticky flag. Software clears a flag by writing a 0 to it. All configuration sits behind a small register port with a combinational read path.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, the count, all capture registers, the flag register (address 8) and all compare output pins read 0.
- R2: Control register (address 0) bits [1:0] pick the tick source: 00 stops counting; 01 counts once every 12 system clocks; 10 is reserved and stops counting; 11 counts each rising edge of `ext_clk`.
- R3: Control bits [3:2] hold a value p, and the count advances once per 2^p ticks of the selected source.
- R4: The count is read at address 9, and a write to address 9 leaves it unchanged.
- R5: When control bit 4 is 1, a rising edge on `ext_rst` sets the count to 0. When the bit is 0, that edge has no effect on the count.
- R6: Edge register (address 1) bit i enables rising-edge capture on `cap_in[i]`, and bit 4+i enables falling-edge capture. With both set, either edge captures; with neither set, the channel's capture register keeps its value.
- R7: A capture on channel i stores the count of that cycle in the register at address 10+i and sets flag bit i.
- R8: When the count takes a new value (increment or clear) equal to compare 0 (address 5), outputs selected by the set mask (address 2) go high and flag bit 4 is set.
- R9: When the count takes a new value equal to compare 1 (address 6), outputs selected by the reset mask (address 3) go low and flag bit 5 is set.
- R10: When the count takes a new value equal to compare 2 (address 7), outputs selected by the toggle mask (address 4) invert and flag bit 6 is set. If several compares hit in the same cycle, the set is applied first, then the reset, then the toggle.
- R11: Flag bit 7 marks overflow. With control bit 5 at 0, it is set when the count wraps from 0xFFFF to 0. With control bit 5 at 1, it is set when the low byte wraps from 0xFF to 0x00.
- R12: A write to address 8 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 as it was. A flag raised by hardware in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data (combinational from addr) |
| cap_in | input | 4 | Capture trigger pins, asynchronous |
| ext_clk | input | 1 | External count clock pin, asynchronous |
| ext_rst | input | 1 | External count clear pin, asynchronous |
| cmp_out | output | 8 | Compare-driven output pins |

## Verification
The three compare actions can hit on the same count value and therefore in the same cycle. That is when the set-then-reset-then-toggle order decides the pins. The bench loads all three compare registers with one value and uses masks that overlap on some bits, so each stage of the order leaves a different mark. It then counts external clock pulses up to that value. The expected pin pattern is computed from the ordering rule and compared with the pins after the hit.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

   typedef enum logic [1:0] {
      MD_HALT   = 2'b00,
      MD_SYSDIV = 2'b01,
      MD_RSVD   = 2'b10,
      MD_EXTCLK = 2'b11
   } tmr_mode_e;

   localparam int A_CTRL = 0;
   localparam int A_EDGE = 1;
   localparam int A_SETM = 2;
   localparam int A_RSTM = 3;
   localparam int A_TOGM = 4;
   localparam int A_CMP0 = 5;
   localparam int A_FLAG = 8;
   localparam int A_TMR  = 9;
   localparam int A_CAP0 = 10;

   localparam int NCMP = 3;

endpackage

// File: rtl/capcmp_sync.sv
module capcmp_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl,
   output logic [W-1:0] prv
);

   logic [W-1:0] meta_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= '0;
         lvl    <= '0;
         prv    <= '0;
      end else begin
         meta_q <= din;
         lvl    <= meta_q;
         prv    <= lvl;
      end
   end

endmodule

// File: rtl/capcmp_timebase.sv
module capcmp_timebase
   import capcmp_pkg::*;
#(
   parameter int TW  = 16,
   parameter int DIV = 12,
   parameter int PSW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic [PSW-1:0] psel,
   input  logic          ext_rise,
   input  logic          clr,
   input  logic          low_sel,
   output logic [TW-1:0] tmr,
   output logic [TW-1:0] tmr_nxt,
   output logic          load,
   output logic          ovf_evt
);

   localparam int PCW = (1 << PSW) - 1;

   logic           sys_tick;
   logic           base_tick;
   logic           inc;
   logic [PCW-1:0] pcnt;
   logic [PCW-1:0] plim;
   logic           pcnt_last;

   generate
      if (DIV > 1) begin : g_div
         localparam int DCW = $clog2(DIV);
         logic [DCW-1:0] dcnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                        dcnt <= '0;
            else if (mode != MD_SYSDIV)        dcnt <= '0;
            else if (dcnt == DCW'(DIV - 1))    dcnt <= '0;
            else                               dcnt <= dcnt + 1'b1;
         end
         assign sys_tick = (mode == MD_SYSDIV) && (dcnt == DCW'(DIV - 1));
      end else begin : g_nodiv
         assign sys_tick = (mode == MD_SYSDIV);
      end
   endgenerate

   assign base_tick = sys_tick | ((mode == MD_EXTCLK) & ext_rise);
   assign plim      = ~({PCW{1'b1}} << psel);
   assign pcnt_last = (pcnt >= plim);

   always_ff @(posedge clk) begin
      if (!rst_n)          pcnt <= '0;
      else if (base_tick)  pcnt <= pcnt_last ? '0 : pcnt + 1'b1;
   end

   assign inc     = base_tick & pcnt_last;
   assign load    = inc | clr;
   assign tmr_nxt = clr ? '0 : tmr + 1'b1;
   assign ovf_evt = inc & ~clr & (low_sel ? (&tmr[7:0]) : (&tmr));

   always_ff @(posedge clk) begin
      if (!rst_n)     tmr <= '0;
      else if (load)  tmr <= tmr_nxt;
   end

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (tmr == $past(tmr) + 1'b1));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(tmr));

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (tmr == '0));

endmodule

// File: rtl/capcmp_capture.sv
module capcmp_capture #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise,
   input  logic          fall,
   input  logic          pos_en,
   input  logic          neg_en,
   input  logic [TW-1:0] tmr,
   output logic [TW-1:0] cap_q,
   output logic          hit
);

   assign hit = (rise & pos_en) | (fall & neg_en);

   always_ff @(posedge clk) begin
      if (!rst_n)    cap_q <= '0;
      else if (hit)  cap_q <= tmr;
   end

   p_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (cap_q == $past(tmr)));

   p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(cap_q));

endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare #(
   parameter int TW   = 16,
   parameter int NOUT = 8,
   parameter int NC   = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [TW-1:0]         tmr_nxt,
   input  logic [NC-1:0][TW-1:0] cmp,
   input  logic [NOUT-1:0]       set_m,
   input  logic [NOUT-1:0]       rst_m,
   input  logic [NOUT-1:0]       tog_m,
   output logic [NC-1:0]         hit,
   output logic [NOUT-1:0]       pin_q
);

   logic [NOUT-1:0] pin_nxt;

   generate
      if (NC != 3) begin : g_bad_nc
         $error("capcmp_compare needs exactly three compare registers");
      end
      for (genvar k = 0; k < NC; k++) begin : g_eq
         assign hit[k] = load && (tmr_nxt == cmp[k]);
      end
   endgenerate

   always_comb begin
      pin_nxt = pin_q;
      if (hit[0]) pin_nxt = pin_nxt | set_m;
      if (hit[1]) pin_nxt = pin_nxt & ~rst_m;
      if (hit[2]) pin_nxt = pin_nxt ^ tog_m;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= pin_nxt;
   end

   p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == 3'b001) |=> ((pin_q & $past(set_m)) == $past(set_m)));

   p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == 3'b010) |=> ((pin_q & $past(rst_m)) == '0));

   p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == 3'b100) |=> (pin_q == ($past(pin_q) ^ $past(tog_m))));

   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |=> $stable(pin_q));

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
   import capcmp_pkg::*;
#(
   parameter int TW   = 16,
   parameter int NCAP = 4,
   parameter int NOUT = 8,
   parameter int DIV  = 12,
   parameter int PSW  = 2,
   parameter int AW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   addr,
   input  logic [TW-1:0]   wdata,
   output logic [TW-1:0]   rdata,
   input  logic [NCAP-1:0] cap_in,
   input  logic            ext_clk,
   input  logic            ext_rst,
   output logic [NOUT-1:0] cmp_out
);

   localparam int NFLG   = NCAP + 4;
   localparam int CTW    = 4 + PSW;
   localparam int B_PS   = 2;
   localparam int B_ERST = 2 + PSW;
   localparam int B_LOW  = 3 + PSW;

   generate
      if (TW < 9 || TW < NFLG || TW < 2 * NCAP || TW < NOUT || TW < CTW) begin : g_bad_w
         $error("capcmp_timer: data width too small for the register layout");
      end
      if (PSW < 1) begin : g_bad_ps
         $error("capcmp_timer: prescaler field needs at least one bit");
      end
      if (A_CAP0 + NCAP > (1 << AW)) begin : g_bad_aw
         $error("capcmp_timer: address width cannot reach all capture registers");
      end
   endgenerate

   logic [CTW-1:0]             ctrl_q;
   logic [2*NCAP-1:0]          edge_q;
   logic [NOUT-1:0]            setm_q, rstm_q, togm_q;
   logic [NCMP-1:0][TW-1:0]    cmp_q;
   logic [NFLG-1:0]            flg_q;
   logic [NFLG-1:0]            flg_set;
   logic                       wr_flag;

   logic [NCAP+1:0]            pin_lvl, pin_prv;
   logic [NCAP-1:0]            cap_rise, cap_fall, cap_hit;
   logic                       clk_rise, clr_rise, clr_req;
   logic [NCAP-1:0][TW-1:0]    cap_q;
   logic [TW-1:0]              tmr, tmr_nxt;
   logic                       load, ovf_evt;
   logic [NCMP-1:0]            cmp_hit;

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         edge_q <= '0;
         setm_q <= '0;
         rstm_q <= '0;
         togm_q <= '0;
         cmp_q  <= '0;
      end else if (wr_en) begin
         if (addr == AW'(A_CTRL)) ctrl_q <= wdata[CTW-1:0];
         if (addr == AW'(A_EDGE)) edge_q <= wdata[2*NCAP-1:0];
         if (addr == AW'(A_SETM)) setm_q <= wdata[NOUT-1:0];
         if (addr == AW'(A_RSTM)) rstm_q <= wdata[NOUT-1:0];
         if (addr == AW'(A_TOGM)) togm_q <= wdata[NOUT-1:0];
         for (int k = 0; k < NCMP; k++) begin
            if (addr == AW'(A_CMP0 + k)) cmp_q[k] <= wdata;
         end
      end
   end

   // pin synchronisers and edge extraction
   capcmp_sync #(.W(NCAP + 2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({ext_rst, ext_clk, cap_in}),
      .lvl   (pin_lvl),
      .prv   (pin_prv)
   );

   assign cap_rise = pin_lvl[NCAP-1:0] & ~pin_prv[NCAP-1:0];
   assign cap_fall = ~pin_lvl[NCAP-1:0] & pin_prv[NCAP-1:0];
   assign clk_rise = pin_lvl[NCAP] & ~pin_prv[NCAP];
   assign clr_rise = pin_lvl[NCAP+1] & ~pin_prv[NCAP+1];
   assign clr_req  = clr_rise & ctrl_q[B_ERST];

   capcmp_timebase #(.TW(TW), .DIV(DIV), .PSW(PSW)) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (ctrl_q[1:0]),
      .psel     (ctrl_q[B_PS +: PSW]),
      .ext_rise (clk_rise),
      .clr      (clr_req),
      .low_sel  (ctrl_q[B_LOW]),
      .tmr      (tmr),
      .tmr_nxt  (tmr_nxt),
      .load     (load),
      .ovf_evt  (ovf_evt)
   );

   generate
      for (genvar i = 0; i < NCAP; i++) begin : g_cap
         capcmp_capture #(.TW(TW)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .rise   (cap_rise[i]),
            .fall   (cap_fall[i]),
            .pos_en (edge_q[i]),
            .neg_en (edge_q[NCAP + i]),
            .tmr    (tmr),
            .cap_q  (cap_q[i]),
            .hit    (cap_hit[i])
         );
      end
   endgenerate

   capcmp_compare #(.TW(TW), .NOUT(NOUT), .NC(NCMP)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .tmr_nxt (tmr_nxt),
      .cmp     (cmp_q),
      .set_m   (setm_q),
      .rst_m   (rstm_q),
      .tog_m   (togm_q),
      .hit     (cmp_hit),
      .pin_q   (cmp_out)
   );

   // sticky event flags
   assign flg_set = {ovf_evt, cmp_hit, cap_hit};
   assign wr_flag = wr_en && (addr == AW'(A_FLAG));

   always_ff @(posedge clk) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= (wr_flag ? (flg_q & wdata[NFLG-1:0]) : flg_q) | flg_set;
   end

   // read path
   always_comb begin
      rdata = '0;
      if (addr == AW'(A_CTRL)) rdata = TW'(ctrl_q);
      if (addr == AW'(A_EDGE)) rdata = TW'(edge_q);
      if (addr == AW'(A_SETM)) rdata = TW'(setm_q);
      if (addr == AW'(A_RSTM)) rdata = TW'(rstm_q);
      if (addr == AW'(A_TOGM)) rdata = TW'(togm_q);
      if (addr == AW'(A_FLAG)) rdata = TW'(flg_q);
      if (addr == AW'(A_TMR))  rdata = tmr;
      for (int k = 0; k < NCMP; k++) begin
         if (addr == AW'(A_CMP0 + k)) rdata = cmp_q[k];
      end
      for (int i = 0; i < NCAP; i++) begin
         if (addr == AW'(A_CAP0 + i)) rdata = cap_q[i];
      end
   end

   p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> ((flg_q & $past(flg_q)) == $past(flg_q)));

   p_capflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_hit != '0) |=> ((flg_q[NCAP-1:0] & $past(cap_hit)) == $past(cap_hit)));

endmodule

// File: tb/capcmp_timer_bench.sv
`timescale 1ns/1ps
module capcmp_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  cap_in = '0;
   logic        ext_clk = 1'b0;
   logic        ext_rst = 1'b0;
   logic [7:0]  cmp_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   capcmp_timer u_capcmp_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .cap_in  (cap_in),
      .ext_clk (ext_clk),
      .ext_rst (ext_rst),
      .cmp_out (cmp_out)
   );

   // {pos_en, neg_en, edge_is_rising, capture_expected}
   localparam logic [3:0] CAPV [8] = '{
      4'b1011, 4'b1000, 4'b0110, 4'b0101,
      4'b1111, 4'b1101, 4'b0010, 4'b0000
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = 4'(a);
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] v);
      @(negedge clk);
      addr = 4'(a);
      #1;
      v = rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_clk = 1'b1;
         @(negedge clk); ext_clk = 1'b0;
      end
      settle();
   endtask

   task automatic clear_pin();
      @(negedge clk); ext_rst = 1'b1;
      @(negedge clk); ext_rst = 1'b0;
      settle();
   endtask

   initial begin
      repeat (199000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v, t0, t1, old;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(9, v);  chk("R1 count after reset", v, 16'h0000);
      rd(8, v);  chk("R1 flags after reset", v, 16'h0000);
      rd(10, v); chk("R1 capture after reset", v, 16'h0000);
      chk("R1 outputs after reset", {8'h00, cmp_out}, 16'h0000);

      // R2 tick sources
      pulses(5); rd(9, v); chk("R2 halted ignores ext clock", v, 16'd0);
      wr(0, 16'h0003); pulses(5); rd(9, v); chk("R2 ext clock counts", v, 16'd5);
      wr(0, 16'h0002); pulses(3); rd(9, v); chk("R2 reserved mode halts", v, 16'd5);

      // R4 read-only count
      wr(9, 16'h1234); rd(9, v); chk("R4 write to count ignored", v, 16'd5);

      // R3 prescaler on external clock
      wr(0, 16'h000B); pulses(16); rd(9, v); chk("R3 prescale 4 on ext clock", v, 16'd9);

      // R2 system clock divided by 12, R3 with prescale 4
      wr(0, 16'h0001); rd(9, t0);
      repeat (120) @(negedge clk); #1; t1 = rdata;
      chk("R2 sysclk/12 over 120 clocks", t1 - t0, 16'd10);
      wr(0, 16'h0009); rd(9, t0);
      repeat (480) @(negedge clk); #1; t1 = rdata;
      chk("R3 prescale 4 over 480 clocks", t1 - t0, 16'd10);

      // R5 external clear
      wr(0, 16'h0003); rd(9, t0);
      clear_pin(); rd(9, v); chk("R5 clear pin ignored when disabled", v, t0);
      wr(0, 16'h0013); clear_pin(); rd(9, v); chk("R5 clear pin zeroes count", v, 16'd0);

      // R6 / R7 capture edge table
      for (int k = 0; k < 8; k++) begin
         int ch;
         logic pe, ne, dir, ex;
         ch = k % 4;
         {pe, ne, dir, ex} = CAPV[k];
         wr(1, 16'h0000);
         @(negedge clk); cap_in[ch] = ~dir;
         settle();
         wr(8, 16'h0000);
         pulses(3);
         rd(9, t0);
         rd(10 + ch, old);
         wr(1, 16'(({7'b0, ne} << (4 + ch)) | ({7'b0, pe} << ch)));
         @(negedge clk); cap_in[ch] = dir;
         settle();
         rd(8, v);
         chk($sformatf("R6 capture flag vector %0d", k), {15'b0, v[ch]}, {15'b0, ex});
         rd(10 + ch, v);
         chk($sformatf("R7 capture value vector %0d", k), v, ex ? t0 : old);
      end
      wr(1, 16'h0000);

      // R8..R10 compare actions
      wr(2, 16'h000F); wr(3, 16'h003C); wr(4, 16'h0081);
      wr(5, 16'd20); wr(6, 16'd30); wr(7, 16'd40);
      clear_pin(); wr(8, 16'h0000);
      pulses(20); chk("R8 set mask on compare 0", {8'h00, cmp_out}, 16'h000F);
      pulses(10); chk("R9 reset mask on compare 1", {8'h00, cmp_out}, 16'h0003);
      pulses(10); chk("R10 toggle mask on compare 2", {8'h00, cmp_out}, 16'h0082);
      rd(8, v); chk("R8 R9 R10 compare flags", v, 16'h0070);
      wr(5, 16'd50); wr(6, 16'd50); wr(7, 16'd50);
      pulses(10); chk("R10 coincident set-reset-toggle order", {8'h00, cmp_out}, 16'h0002);

      // R12 write-0-to-clear
      wr(8, 16'h0000);
      wr(8, 16'h0000);
      rd(8, v); chk("R12 all flags cleared", v, 16'h0000);
      wr(5, 16'd60); pulses(10);
      rd(8, v); chk("R12 flag raised again", v, 16'h0010);
      wr(8, 16'hFFFF); rd(8, v); chk("R12 writing ones keeps flags", v, 16'h0010);
      wr(8, 16'hFFEF); rd(8, v); chk("R12 writing zero clears flag", v, 16'h0000);

      // R11 low-byte overflow
      wr(0, 16'h0033); clear_pin(); wr(8, 16'h0000);
      pulses(255); rd(8, v); chk("R11 no low-byte wrap yet", {15'b0, v[7]}, 16'd0);
      pulses(1);   rd(8, v); chk("R11 low-byte wrap flag", {15'b0, v[7]}, 16'd1);

      // R11 full-width overflow
      wr(0, 16'h0013); wr(8, 16'h0000);
      pulses(65279);
      rd(9, v); chk("R11 count at top", v, 16'hFFFF);
      rd(8, v); chk("R11 no overflow before wrap", {15'b0, v[7]}, 16'd0);
      pulses(1);
      rd(9, v); chk("R11 count wrapped", v, 16'h0000);
      rd(8, v); chk("R11 full overflow flag", {15'b0, v[7]}, 16'd1);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule